// File: doc/BRIEF.md
# Six-Channel DMA Priority Arbiter

This block decides which of six DMA channels owns the single shared transfer engine. Each channel presents a request line and a run line. The engine reports back with a word-done pulse after every word it moves and a burst-done pulse with the last word of a burst. The arbiter registers its decision and drives a one-hot grant vector and a small status code that names the channel being served.

Channels of equal standing take turns. At every burst end the next grant goes to the first eligible channel after the one that just finished, counting upward and wrapping from 6 back to 1. A configuration input can promote channel 1 above all others. When channel 1 is promoted it may take the engine from another channel between two words. The interrupted channel is then recorded in a second status code, and it gets the engine back as soon as channel 1's burst ends. A one-cycle restart strobe sets the rotation back so that it starts again at channel 1.

Top module: `dma_prio_arb`

## Requirements
- R1: While reset is held low at a clock edge, the grant becomes all zeros and both status codes become 0.
- R2: The active status is 0 when no channel is served, or k (1..6) when channel k is served. In that case grant bit k-1 is the only bit set. Every decision shows on the outputs one clock after the inputs that caused it.
- R3: With channel-1 promotion off, a new grant (from idle, or at a burst end) goes to the first eligible channel after the last channel whose burst completed. The search counts upward and wraps from 6 to 1. After reset the search starts at channel 1.
- R4: A granted channel keeps the grant until burst-done is seen, except when a preemption under R6 takes place.
- R5: With promotion on and channel 1 eligible, a new grant from idle or at a burst end goes to channel 1 ahead of the rotation. The only exception is a resume under R8.
- R6: With promotion on, suppose channel 1 is eligible while channel 2..6 is served, word-done is high, and neither burst-done nor the restart strobe is high. Then channel 1 is granted on the next clock, and the shadow status takes the number of the channel that was served.
- R7: When channel 1 is granted by promotion with no channel preempted, the shadow status becomes 0. The shadow status never reads 1. Otherwise it keeps its value.
- R8: When the burst of a preempting channel 1 ends, the channel named in the shadow status is granted next if it is still eligible. If it is not, the normal choice is made. Rotation then continues after the resumed channel's burst.
- R9: The restart strobe makes the next rotation search start at channel 1. It cancels any pending resume and clears the shadow status to 0. It does not take the grant away from a channel being served.
- R10: A channel whose run input is low is never granted, whatever its request line shows.
- R11: If no channel is eligible when a new grant is due, the grant becomes all zeros and the active status becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ch_req | input | 6 | Request per channel, bit k-1 for channel k |
| ch_run | input | 6 | Run status per channel; low masks the request |
| ch1_promote | input | 1 | Gives channel 1 preemptive top priority |
| restart_rr | input | 1 | One-cycle strobe restarting the rotation at channel 1 |
| word_done | input | 1 | Engine finished a word of the granted channel |
| burst_done | input | 1 | Engine finished the last word of the burst |
| grant | output | 6 | One-hot grant, bit k-1 for channel k |
| active_sts | output | 3 | Channel being served, 0 when idle |
| shadow_sts | output | 3 | Channel preempted by channel 1, or 0 |

## Verification
The assertions take for granted that the engine raises burst-done only while a channel holds the grant, and that burst-done always comes together with word-done. They also rely on the fact that a channel's run state does not need to stay high for the grant to remain valid. The stimulus follows these rules because it derives each burst-done from the reference model's own view of the active channel, and it forces word-done high whenever it raises burst-done. Request, run, promotion and restart inputs are otherwise randomised freely, so preemptions, dropped resumes and restarts in mid-burst all occur.

// File: rtl/dma_arb_pkg.sv
// Package: shared types for the six-channel DMA arbiter.
// Assumes: nothing; holds only the selection-source encoding.
package dma_arb_pkg;

    // Which rule produced the next grant
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_RESUME = 2'd1,
        SRC_PROMO  = 2'd2,
        SRC_ROT    = 2'd3
    } sel_src_t;

endpackage

// File: rtl/dma_arb_rr_pick.sv
// Module: rotating search for the first eligible channel after a base.
// Assumes: base is 0..NUM_CH; base 0 means the search starts at channel 1.
// Channel numbers are 1-based; pick_id is 0 when nothing is eligible.
module dma_arb_rr_pick #(
    parameter int NUM_CH = 6,
    parameter int ID_W   = $clog2(NUM_CH + 1)
) (
    input  logic [NUM_CH-1:0] elig,
    input  logic [ID_W-1:0]   base,
    output logic              found,
    output logic [ID_W-1:0]   pick_id
);

    // Scan NUM_CH positions starting just after base, keep the first hit
    always_comb begin
        found   = 1'b0;
        pick_id = '0;
        for (int off = 1; off <= NUM_CH; off++) begin
            int slot;
            slot = (int'(base) + off - 1) % NUM_CH;
            if (!found && elig[slot]) begin
                found   = 1'b1;
                pick_id = ID_W'(slot + 1);
            end
        end
    end

endmodule

// File: rtl/dma_arb_sel.sv
// Module: combines resume, channel-1 promotion and rotation into one choice.
// Assumes: resume_id names a channel 2..NUM_CH whenever resume_req is high.
// Order: resume of a preempted channel, then promoted channel 1, then rotation.
module dma_arb_sel
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ID_W   = $clog2(NUM_CH + 1)
) (
    input  logic [NUM_CH-1:0] elig,
    input  logic              promote,
    input  logic              resume_req,
    input  logic [ID_W-1:0]   resume_id,
    input  logic [ID_W-1:0]   rot_base,
    output logic [ID_W-1:0]   next_id,
    output sel_src_t          next_src
);

    logic            rot_found;
    logic [ID_W-1:0] rot_id;
    logic            resume_elig;

    dma_arb_rr_pick #(
        .NUM_CH (NUM_CH),
        .ID_W   (ID_W)
    ) rot_i (
        .elig    (elig),
        .base    (rot_base),
        .found   (rot_found),
        .pick_id (rot_id)
    );

    // Look up whether the channel waiting to resume is still eligible
    always_comb begin
        resume_elig = 1'b0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (resume_id == ID_W'(k + 1)) begin
                resume_elig = elig[k];
            end
        end
    end

    // Apply the fixed precedence of the three selection rules
    always_comb begin
        if (resume_req && resume_elig) begin
            next_id  = resume_id;
            next_src = SRC_RESUME;
        end else if (promote && elig[0]) begin
            next_id  = ID_W'(1);
            next_src = SRC_PROMO;
        end else if (rot_found) begin
            next_id  = rot_id;
            next_src = SRC_ROT;
        end else begin
            next_id  = '0;
            next_src = SRC_NONE;
        end
    end

endmodule

// File: rtl/dma_arb_grant_dec.sv
// Module: turns a 1-based channel number into a one-hot grant vector.
// Assumes: id is 0..NUM_CH; 0 gives an all-zero vector.
module dma_arb_grant_dec #(
    parameter int NUM_CH = 6,
    parameter int ID_W   = $clog2(NUM_CH + 1)
) (
    input  logic [ID_W-1:0]   id,
    output logic [NUM_CH-1:0] onehot
);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_bit
        // One comparator per grant bit
        assign onehot[k] = (id == ID_W'(k + 1));
    end

endmodule

// File: rtl/dma_prio_arb.sv
// Module: six-channel DMA arbiter with rotation, optional preemptive
// channel 1 and a record of the preempted channel.
// Assumes: burst_done is raised only while a channel is granted and always
// together with word_done; all inputs are synchronous to clk.
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int ID_W   = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic [NUM_CH-1:0] ch_run,
    input  logic              ch1_promote,
    input  logic              restart_rr,
    input  logic              word_done,
    input  logic              burst_done,
    output logic [NUM_CH-1:0] grant,
    output logic [ID_W-1:0]   active_sts,
    output logic [ID_W-1:0]   shadow_sts
);

    logic [NUM_CH-1:0] elig;
    logic [ID_W-1:0]   cur_q;
    logic [ID_W-1:0]   last_q;
    logic [ID_W-1:0]   shadow_q;
    logic              pend_q;

    logic              busy;
    logic              release_go;
    logic              preempt_go;
    logic              select_go;
    logic              ch1_pend_rel;
    logic              counts_done;
    logic [ID_W-1:0]   rot_base;
    logic [ID_W-1:0]   next_id;
    sel_src_t          next_src;

    // Mask requests by run status
    assign elig = ch_req & ch_run;

    // Control decode for this cycle
    always_comb begin
        busy         = (cur_q != '0);
        release_go   = busy && burst_done;
        ch1_pend_rel = release_go && (cur_q == ID_W'(1)) && pend_q;
        counts_done  = release_go && !ch1_pend_rel;
        preempt_go   = ch1_promote && elig[0] && (cur_q > ID_W'(1))
                       && word_done && !burst_done && !restart_rr;
        select_go    = !busy || release_go;
        if (restart_rr) begin
            rot_base = '0;
        end else if (counts_done) begin
            rot_base = cur_q;
        end else begin
            rot_base = last_q;
        end
    end

    dma_arb_sel #(
        .NUM_CH (NUM_CH),
        .ID_W   (ID_W)
    ) sel_i (
        .elig       (elig),
        .promote    (ch1_promote),
        .resume_req (ch1_pend_rel && !restart_rr),
        .resume_id  (shadow_q),
        .rot_base   (rot_base),
        .next_id    (next_id),
        .next_src   (next_src)
    );

    // Channel being served
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (preempt_go) begin
            cur_q <= ID_W'(1);
        end else if (select_go) begin
            cur_q <= next_id;
        end
    end

    // Last channel whose burst counted for the rotation
    always_ff @(posedge clk) begin
        if (!rst_n || restart_rr) begin
            last_q <= '0;
        end else if (!preempt_go && counts_done) begin
            last_q <= cur_q;
        end
    end

    // Pending resume of a preempted channel
    always_ff @(posedge clk) begin
        if (!rst_n || restart_rr) begin
            pend_q <= 1'b0;
        end else if (preempt_go) begin
            pend_q <= 1'b1;
        end else if (ch1_pend_rel) begin
            pend_q <= 1'b0;
        end
    end

    // Record of the channel channel 1 took the engine from
    always_ff @(posedge clk) begin
        if (!rst_n || restart_rr) begin
            shadow_q <= '0;
        end else if (preempt_go) begin
            shadow_q <= cur_q;
        end else if (select_go && next_src == SRC_PROMO) begin
            shadow_q <= '0;
        end
    end

    dma_arb_grant_dec #(
        .NUM_CH (NUM_CH),
        .ID_W   (ID_W)
    ) dec_i (
        .id     (cur_q),
        .onehot (grant)
    );

    assign active_sts = cur_q;
    assign shadow_sts = shadow_q;

    // R2: grant is one-hot or empty and agrees with the status code
    a_r2_grant_matches: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant == '0) == (active_sts == '0)));

    // R4: without burst end or preemption the served channel stays
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (active_sts != '0 && !burst_done
         && !(ch1_promote && ch_req[0] && ch_run[0] && word_done))
        |=> $stable(active_sts));

    // R6: preemption at a word boundary records the interrupted channel
    a_r6_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        (ch1_promote && ch_req[0] && ch_run[0] && active_sts > ID_W'(1)
         && word_done && !burst_done && !restart_rr)
        |=> (active_sts == ID_W'(1)) && (shadow_sts == $past(active_sts)));

    // R7: the shadow status never reads 1
    a_r7_shadow_not_one: assert property (@(posedge clk) disable iff (!rst_n)
        shadow_sts != ID_W'(1));

    // R10: a newly granted channel was eligible in the deciding cycle
    a_r10_only_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (active_sts != '0 && active_sts != $past(active_sts))
        |-> ((($past(ch_req & ch_run)) >> (active_sts - ID_W'(1)))
             & NUM_CH'(1)) != '0);

    // R11: nothing eligible at a decision point leaves the engine idle
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((ch_req & ch_run) == '0 && (active_sts == '0 || burst_done))
        |=> (active_sts == '0) && (grant == '0));

endmodule

// File: tb/dma_prio_arb_tb_top.sv
module dma_prio_arb_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] ch_req = '0;
    logic [5:0] ch_run = '0;
    logic       ch1_promote = 1'b0;
    logic       restart_rr = 1'b0;
    logic       word_done = 1'b0;
    logic       burst_done = 1'b0;
    logic [5:0] grant;
    logic [2:0] active_sts;
    logic [2:0] shadow_sts;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    // reference model state
    int m_cur = 0;
    int m_last = 0;
    int m_shadow = 0;
    bit m_pend = 1'b0;

    always #2 clk = ~clk;

    dma_prio_arb dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_req      (ch_req),
        .ch_run      (ch_run),
        .ch1_promote (ch1_promote),
        .restart_rr  (restart_rr),
        .word_done   (word_done),
        .burst_done  (burst_done),
        .grant       (grant),
        .active_sts  (active_sts),
        .shadow_sts  (shadow_sts)
    );

    function automatic logic [5:0] exp_grant(input int a);
        return (a == 0) ? 6'd0 : 6'(1 << (a - 1));
    endfunction

    // reference model: behavioural next-state from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur = 0; m_last = 0; m_shadow = 0; m_pend = 1'b0;
        end else begin
            logic [5:0] el;
            bit rel, own_rel, decide, took;
            int base, pick;
            el = ch_req & ch_run;
            rel = (m_cur != 0) && burst_done;
            decide = (m_cur == 0) || rel;
            if (ch1_promote && el[0] && m_cur >= 2 && word_done && !burst_done && !restart_rr) begin
                m_shadow = m_cur; m_pend = 1'b1; m_cur = 1;
            end else begin
                own_rel = rel && !(m_cur == 1 && m_pend);
                base = restart_rr ? 0 : (own_rel ? m_cur : m_last);
                pick = 0;
                took = 1'b0;
                if (decide) begin
                    if (rel && m_cur == 1 && m_pend && !restart_rr && el[m_shadow-1]) begin
                        pick = m_shadow;
                    end else if (ch1_promote && el[0]) begin
                        pick = 1; took = 1'b1;
                    end else begin
                        for (int i = 1; i <= 6; i++) begin
                            int c;
                            c = ((base + i - 1) % 6) + 1;
                            if (pick == 0 && el[c-1]) pick = c;
                        end
                    end
                end
                if (restart_rr || (rel && m_cur == 1)) m_pend = 1'b0;
                if (restart_rr || took) m_shadow = 0;
                m_last = restart_rr ? 0 : (own_rel ? m_cur : m_last);
                if (decide) m_cur = pick;
            end
        end
    end

    // compare with the model on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            checks++;
            if (grant !== exp_grant(m_cur) || active_sts !== 3'(m_cur)) begin
                errors++;
                $display("FAIL R2 model: grant=%b active=%0d expected grant=%b active=%0d",
                         grant, active_sts, exp_grant(m_cur), m_cur);
            end
            checks++;
            if (shadow_sts !== 3'(m_shadow)) begin
                errors++;
                $display("FAIL R7 model: shadow=%0d expected %0d", shadow_sts, m_shadow);
            end
        end
    end

    task automatic step(input logic [5:0] rq, input logic [5:0] rn,
                        input logic wd, input logic bd, input logic hp, input logic pr);
        ch_req = rq; ch_run = rn; word_done = wd; burst_done = bd;
        ch1_promote = hp; restart_rr = pr;
        @(negedge clk);
    endtask

    task automatic expect_out(input int a, input int s, input string tag);
        checks++;
        if (grant !== exp_grant(a) || active_sts !== 3'(a) || shadow_sts !== 3'(s)) begin
            errors++;
            $display("FAIL %s: grant=%b active=%0d shadow=%0d expected grant=%b active=%0d shadow=%0d",
                     tag, grant, active_sts, shadow_sts, exp_grant(a), a, s);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        expect_out(0, 0, "R1 reset state");
        rst_n = 1'b1;
        // rotation, promotion off
        step(6'b010100, 6'h3F, 0, 0, 0, 0);
        expect_out(3, 0, "R3 first pick from reset");
        step(6'b010100, 6'h3F, 1, 0, 0, 0);
        expect_out(3, 0, "R4 word_done alone holds grant");
        step(6'b010100, 6'h3F, 1, 1, 0, 0);
        expect_out(5, 0, "R3 rotate to next");
        step(6'b010100, 6'h3F, 1, 1, 0, 0);
        expect_out(3, 0, "R3 wrap from 6 to 1");
        // ch4 requests with run low, ch2 eligible
        step(6'b001010, 6'b110111, 1, 1, 0, 0);
        expect_out(2, 0, "R10 run-low request ignored");
        step(6'b000000, 6'h3F, 1, 1, 0, 0);
        expect_out(0, 0, "R11 no request idle");
        // without restart the pick after ch2 would be ch3
        step(6'b000101, 6'h3F, 0, 0, 0, 1);
        expect_out(1, 0, "R9 restart begins at channel 1");
        step(6'b000000, 6'h3F, 1, 1, 0, 0);
        expect_out(0, 0, "R11 idle after release");
        // promotion on
        step(6'b001000, 6'h3F, 0, 0, 1, 0);
        expect_out(4, 0, "R5 rotation when ch1 absent");
        step(6'b001001, 6'h3F, 1, 0, 1, 0);
        expect_out(1, 4, "R6 preempt at word boundary");
        step(6'b011001, 6'h3F, 1, 1, 1, 0);
        expect_out(4, 4, "R8 resume preempted channel");
        step(6'b010001, 6'h3F, 1, 1, 1, 0);
        expect_out(1, 0, "R5 promoted ch1 at burst end");
        step(6'b110000, 6'h3F, 1, 1, 1, 0);
        expect_out(5, 0, "R3 rotation continues");
        step(6'b010001, 6'h3F, 1, 0, 0, 0);
        expect_out(5, 0, "R6 no preempt when promotion off");
        step(6'b010001, 6'h3F, 0, 0, 1, 0);
        expect_out(5, 0, "R6 no preempt between words");
        step(6'b010001, 6'h3F, 1, 0, 1, 0);
        expect_out(1, 5, "R6 preempt ch5");
        step(6'b000000, 6'h3F, 1, 1, 1, 0);
        expect_out(0, 5, "R8 resume dropped when not eligible");
        step(6'b000001, 6'h3F, 0, 0, 1, 0);
        expect_out(1, 0, "R7 shadow zero with no preempted channel");
        step(6'b000000, 6'h3F, 0, 0, 1, 1);
        expect_out(1, 0, "R9 restart keeps current grant");
        // randomised phase, checked against the model each cycle
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] rq, rn;
            logic wd, bd, hp, pr;
            rq = 6'($urandom);
            rn = ~(6'($urandom) & 6'($urandom) & 6'($urandom));
            wd = 1'($urandom);
            bd = (m_cur != 0) && ($urandom % 4 == 0);
            if (bd) wd = 1'b1;
            hp = ((i / 300) % 2) == 1;
            pr = ($urandom % 60) == 0;
            step(rq, rn, wd, bd, hp, pr);
        end
        finish_run();
    end

endmodule